// File: doc/BRIEF.md
# Smart Card Baud Divisor Calculator

This block turns a pair of 4-bit rate indices into the settings a smart card UART needs: an 8-bit bit-clock divisor and a choice between 12x and 8x oversampling. The first index selects a clock-rate conversion factor F and the second an adjustment factor D. The ratio of the two is the number of card clocks per bit. That ratio is split into an oversampling rate times a divisor. The 12x rate is tried first and 8x is the fallback.

D can be a fraction as small as 1/64, so it is held pre-multiplied by 64. The ratio is then formed as (64*F) divided by that scaled D, using integer arithmetic only. One shared restoring divider does all the arithmetic: the F/D ratio, the test by 12 and the test by 8. A control state machine sequences it. A single-cycle start pulse launches a calculation. A single-cycle done pulse ends it and comes with an error code. The divisor and oversampling outputs change only when a calculation succeeds, so the UART keeps its last good setting if the card asks for something unsupported.

Top module: `baud_div_calc`

## Requirements
- R1: After reset the block outputs divisor 31, sample12 1, errCode 0 and done 0. These values match F=372 with D=1.
- R2: The F index maps to these values: 1→372, 2→558, 3→744, 4→1116, 5→1488, 6→1860, 9→512, 10→768, 11→1024, 12→1536, 13→2048. Indices 0, 7, 8, 14 and 15 give errCode 1 (invalid index). For an invalid index, done rises in the clock cycle right after the one in which start was sampled.
- R3: The D index maps to these scaled values (D times 64): 1→64, 2→128, 3→256, 4→512, 5→1024, 10→32, 11→16, 12→8, 13→4, 14→2, 15→1. Indices 0 and 6 to 9 give errCode 1.
- R4: If 64*F is not an exact multiple of the scaled D, the calculation ends with errCode 2 (fractional ratio).
- R5: If the ratio is a multiple of 12, success (errCode 0) sets sample12=1 and divisor=ratio/12. This holds even when the ratio is also a multiple of 8.
- R6: If the ratio is a multiple of 8 but not of 12, success sets sample12=0 and divisor=ratio/8.
- R7: If the integer ratio is a multiple of neither 12 nor 8, the calculation ends with errCode 3.
- R8: If the selected quotient is 256 or more, the calculation ends with errCode 4. Exactly 256 counts as out of range.
- R9: Every error leaves divisor and sample12 at the values they held before the calculation.
- R10: Each calculation produces exactly one single-cycle done pulse. errCode changes only together with done and holds its value until the next done.
- R11: A start pulse that arrives while a calculation is running is ignored. The running calculation finishes with its own result, and no second done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a calculation with the current indices |
| fIdx | input | 4 | Clock-rate conversion index (selects F) |
| dIdx | input | 4 | Rate adjustment index (selects D) |
| divisor | output | 8 | Bit-clock divisor from the last successful calculation |
| sample12 | output | 1 | 1 = 12x oversampling, 0 = 8x |
| done | output | 1 | One-cycle pulse when a calculation ends |
| errCode | output | 3 | 0 ok, 1 invalid index, 2 fraction, 3 not divisible, 4 range |

## Verification
The assertions assume start is a single-cycle pulse. They also assume that no new start is raised in the same cycle that done is high, because an immediate restart with a bad index could put two done pulses back to back. The bench always drops start after one cycle. It waits at least one cycle after each done before it issues the next start. When it raises start during a running calculation, it does so only in the middle of that run, well clear of the done cycle.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

  localparam int F_W = 12;   // widest F value (2048)
  localparam int D_W = 11;   // widest scaled D value (1024)
  localparam int SCALE_SH = 6; // D is held times 64

  typedef enum logic [2:0] {
    ERR_OK    = 3'd0,
    ERR_INDEX = 3'd1,
    ERR_FRAC  = 3'd2,
    ERR_NODIV = 3'd3,
    ERR_RANGE = 3'd4
  } calcErr_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RATIO,
    ST_BY12,
    ST_BY8
  } calcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadRatio;
    logic loadBy12;
    logic loadBy8;
    logic commit12;
    logic commit8;
  } ctrlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic idxBad;
    logic divDone;
    logic remZero;
    logic quotHigh;
  } dpStatus_t;

  // {valid, F}
  function automatic logic [F_W:0] fEntry(input logic [3:0] idx);
    case (idx)
      4'd1:    return {1'b1, 12'd372};
      4'd2:    return {1'b1, 12'd558};
      4'd3:    return {1'b1, 12'd744};
      4'd4:    return {1'b1, 12'd1116};
      4'd5:    return {1'b1, 12'd1488};
      4'd6:    return {1'b1, 12'd1860};
      4'd9:    return {1'b1, 12'd512};
      4'd10:   return {1'b1, 12'd768};
      4'd11:   return {1'b1, 12'd1024};
      4'd12:   return {1'b1, 12'd1536};
      4'd13:   return {1'b1, 12'd2048};
      default: return '0;
    endcase
  endfunction

  // {valid, 64*D}
  function automatic logic [D_W:0] dEntry(input logic [3:0] idx);
    case (idx)
      4'd1:    return {1'b1, 11'd64};
      4'd2:    return {1'b1, 11'd128};
      4'd3:    return {1'b1, 11'd256};
      4'd4:    return {1'b1, 11'd512};
      4'd5:    return {1'b1, 11'd1024};
      4'd10:   return {1'b1, 11'd32};
      4'd11:   return {1'b1, 11'd16};
      4'd12:   return {1'b1, 11'd8};
      4'd13:   return {1'b1, 11'd4};
      4'd14:   return {1'b1, 11'd2};
      4'd15:   return {1'b1, 11'd1};
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/baud_div_divider.sv
module baud_div_divider #(
  parameter int NUM_W = 18,
  parameter int DEN_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startDiv,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             divDone,
  output logic [NUM_W-1:0] quot,
  output logic [DEN_W-1:0] rem
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

  logic [NUM_W-1:0] qR;
  logic [DEN_W-1:0] remR;
  logic [DEN_W-1:0] denR;
  logic [CNT_W-1:0] cnt;
  logic             busyR;
  logic             doneR;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   diff;
  logic             ge;

  always_comb begin
    shifted = {remR, qR[NUM_W-1]};
    ge      = shifted >= {1'b0, denR};
    diff    = shifted - {1'b0, denR};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qR    <= '0;
      remR  <= '0;
      denR  <= '0;
      cnt   <= '0;
      busyR <= 1'b0;
      doneR <= 1'b0;
    end else begin
      doneR <= 1'b0;
      if (startDiv) begin
        qR    <= num;
        remR  <= '0;
        denR  <= den;
        cnt   <= '0;
        busyR <= 1'b1;
      end else if (busyR) begin
        remR <= DEN_W'(ge ? diff : shifted);
        qR   <= {qR[NUM_W-2:0], ge};
        cnt  <= cnt + 1'b1;
        if (cnt == LAST) begin
          busyR <= 1'b0;
          doneR <= 1'b1;
        end
      end
    end
  end

  assign divDone = doneR;
  assign quot    = qR;
  assign rem     = remR;
endmodule

// File: rtl/baud_div_dp.sv
module baud_div_dp
  import baud_div_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] fIdx,
  input  logic [IDX_W-1:0] dIdx,
  input  ctrlStrobe_t      strobe,
  output dpStatus_t        status,
  output logic [DIV_W-1:0] divisor,
  output logic             sample12
);
  localparam int NUM_W = F_W + SCALE_SH;
  localparam logic [DIV_W-1:0] RST_DIV = DIV_W'(31);

  logic [F_W:0]       fEnt;
  logic [D_W:0]       dEnt;
  logic [NUM_W-1:0]   ratioR;
  logic [NUM_W-1:0]   numSel;
  logic [D_W-1:0]     denSel;
  logic               divStart;
  logic               divDone;
  logic [NUM_W-1:0]   quot;
  logic [D_W-1:0]     rem;
  logic [DIV_W-1:0]   divisorR;
  logic               sample12R;

  always_comb begin
    fEnt = fEntry(4'(fIdx));
    dEnt = dEntry(4'(dIdx));
  end

  // operand select for the shared divider
  always_comb begin
    divStart = strobe.loadRatio | strobe.loadBy12 | strobe.loadBy8;
    numSel   = ratioR;
    denSel   = D_W'(8);
    if (strobe.loadRatio) begin
      numSel = {fEnt[F_W-1:0], {SCALE_SH{1'b0}}};
      denSel = dEnt[D_W-1:0];
    end else if (strobe.loadBy12) begin
      numSel = quot;
      denSel = D_W'(12);
    end
  end

  baud_div_divider #(.NUM_W(NUM_W), .DEN_W(D_W)) i_div (
    .clk     (clk),
    .rstN    (rstN),
    .startDiv(divStart),
    .num     (numSel),
    .den     (denSel),
    .divDone (divDone),
    .quot    (quot),
    .rem     (rem)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioR    <= '0;
      divisorR  <= RST_DIV;
      sample12R <= 1'b1;
    end else begin
      if (strobe.loadBy12) ratioR <= quot;
      if (strobe.commit12) begin
        divisorR  <= quot[DIV_W-1:0];
        sample12R <= 1'b1;
      end else if (strobe.commit8) begin
        divisorR  <= quot[DIV_W-1:0];
        sample12R <= 1'b0;
      end
    end
  end

  always_comb begin
    status.idxBad   = ~fEnt[F_W] | ~dEnt[D_W];
    status.divDone  = divDone;
    status.remZero  = (rem == '0);
    status.quotHigh = |quot[NUM_W-1:DIV_W];
  end

  assign divisor  = divisorR;
  assign sample12 = sample12R;
endmodule

// File: rtl/baud_div_ctrl.sv
module baud_div_ctrl
  import baud_div_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic [2:0]  errCode
);
  calcState_t state, nextState;
  calcErr_t   errR, errNext;
  logic       doneR, setDone;

  always_comb begin
    nextState = state;
    strobe    = '0;
    setDone   = 1'b0;
    errNext   = errR;
    case (state)
      ST_IDLE: begin
        if (start) begin
          if (status.idxBad) begin
            setDone = 1'b1;
            errNext = ERR_INDEX;
          end else begin
            strobe.loadRatio = 1'b1;
            nextState        = ST_RATIO;
          end
        end
      end
      ST_RATIO: begin
        if (status.divDone) begin
          if (!status.remZero) begin
            setDone   = 1'b1;
            errNext   = ERR_FRAC;
            nextState = ST_IDLE;
          end else begin
            strobe.loadBy12 = 1'b1;
            nextState       = ST_BY12;
          end
        end
      end
      ST_BY12: begin
        if (status.divDone) begin
          if (status.remZero) begin
            setDone   = 1'b1;
            nextState = ST_IDLE;
            if (status.quotHigh) errNext = ERR_RANGE;
            else begin
              errNext         = ERR_OK;
              strobe.commit12 = 1'b1;
            end
          end else begin
            strobe.loadBy8 = 1'b1;
            nextState      = ST_BY8;
          end
        end
      end
      ST_BY8: begin
        if (status.divDone) begin
          setDone   = 1'b1;
          nextState = ST_IDLE;
          if (!status.remZero) errNext = ERR_NODIV;
          else if (status.quotHigh) errNext = ERR_RANGE;
          else begin
            errNext        = ERR_OK;
            strobe.commit8 = 1'b1;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errR  <= ERR_OK;
      doneR <= 1'b0;
    end else begin
      state <= nextState;
      doneR <= setDone;
      if (setDone) errR <= errNext;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = doneR;
  assign errCode = errR;
endmodule

// File: rtl/baud_div_calc.sv
module baud_div_calc
  import baud_div_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [IDX_W-1:0] fIdx,
  input  logic [IDX_W-1:0] dIdx,
  output logic [DIV_W-1:0] divisor,
  output logic             sample12,
  output logic             done,
  output logic [2:0]       errCode
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;
  logic        ctrlBusy;
  logic        idxBad;

  baud_div_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strobe (strobe),
    .busy   (ctrlBusy),
    .done   (done),
    .errCode(errCode)
  );

  baud_div_dp #(.IDX_W(IDX_W), .DIV_W(DIV_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .fIdx    (fIdx),
    .dIdx    (dIdx),
    .strobe  (strobe),
    .status  (status),
    .divisor (divisor),
    .sample12(sample12)
  );

  assign idxBad = status.idxBad;
endmodule

// File: rtl/baud_div_calc_chk.sv
module baud_div_calc_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [DIV_W-1:0] divisor,
  input logic             sample12,
  input logic             done,
  input logic [2:0]       errCode,
  input logic             ctrlBusy,
  input logic             idxBad
);
  // R9: settings move only on a successful done
  a_r9_hold_unless_ok: assert property (@(posedge clk) disable iff (!rstN)
    !(done && errCode == 3'd0) |-> ($stable(divisor) && $stable(sample12)));

  // R10: error code changes only together with done
  a_r10_err_stable: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(errCode));

  // R10: control has returned to idle when done is shown
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !ctrlBusy);

  // R2 / R3: bad index reported one cycle after start
  a_r2_invalid_latency: assert property (@(posedge clk) disable iff (!rstN)
    (start && !ctrlBusy && idxBad) |=> (done && errCode == 3'd1));
endmodule

bind baud_div_calc baud_div_calc_chk #(.DIV_W(DIV_W)) i_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .divisor (divisor),
  .sample12(sample12),
  .done    (done),
  .errCode (errCode),
  .ctrlBusy(ctrlBusy),
  .idxBad  (idxBad)
);

// File: tb/test_baud_div_calc.sv
module test_baud_div_calc;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [3:0] fIdx = '0;
  logic [3:0] dIdx = '0;
  logic [7:0] divisor;
  logic       sample12;
  logic       done;
  logic [2:0] errCode;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] modelDiv = 8'd31;
  logic       modelS12 = 1'b1;

  always #5 clk = ~clk;

  baud_div_calc i_baud_div_calc (
    .clk(clk), .rstN(rstN), .start(start), .fIdx(fIdx), .dIdx(dIdx),
    .divisor(divisor), .sample12(sample12), .done(done), .errCode(errCode)
  );

  typedef struct packed {
    logic [3:0] f;
    logic [3:0] d;
    logic [2:0] err;
    logic [7:0] dv;
    logic       s12;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  4'd1,  3'd0, 8'd31,  1'b1, 4'd5},  // R5 ratio 372
    '{4'd9,  4'd1,  3'd0, 8'd64,  1'b0, 4'd6},  // R6 ratio 512
    '{4'd3,  4'd2,  3'd0, 8'd31,  1'b1, 4'd5},  // R5 744/2
    '{4'd13, 4'd2,  3'd0, 8'd128, 1'b0, 4'd6},  // R6 ratio 1024
    '{4'd1,  4'd3,  3'd3, 8'd0,   1'b0, 4'd7},  // R7 ratio 93
    '{4'd1,  4'd5,  3'd2, 8'd0,   1'b0, 4'd4},  // R4 23.25
    '{4'd1,  4'd4,  3'd2, 8'd0,   1'b0, 4'd4},  // R4 46.5
    '{4'd6,  4'd10, 3'd4, 8'd0,   1'b0, 4'd8},  // R8 310
    '{4'd11, 4'd10, 3'd4, 8'd0,   1'b0, 4'd8},  // R8 exactly 256 by 8
    '{4'd12, 4'd10, 3'd4, 8'd0,   1'b0, 4'd8},  // R8 exactly 256 by 12
    '{4'd10, 4'd5,  3'd0, 8'd4,   1'b1, 4'd5},  // R5 ratio 48
    '{4'd13, 4'd5,  3'd0, 8'd16,  1'b0, 4'd6},  // R6 ratio 128
    '{4'd0,  4'd1,  3'd1, 8'd0,   1'b0, 4'd2},  // R2 zero F
    '{4'd7,  4'd1,  3'd1, 8'd0,   1'b0, 4'd2},  // R2 reserved F
    '{4'd15, 4'd1,  3'd1, 8'd0,   1'b0, 4'd2},  // R2 reserved F
    '{4'd1,  4'd0,  3'd1, 8'd0,   1'b0, 4'd3},  // R3 zero D
    '{4'd1,  4'd6,  3'd1, 8'd0,   1'b0, 4'd3},  // R3 reserved D
    '{4'd1,  4'd9,  3'd1, 8'd0,   1'b0, 4'd3},  // R3 reserved D
    '{4'd6,  4'd1,  3'd0, 8'd155, 1'b1, 4'd2},  // R2 F=1860
    '{4'd4,  4'd1,  3'd0, 8'd93,  1'b1, 4'd2},  // R2 F=1116
    '{4'd1,  4'd12, 3'd0, 8'd248, 1'b1, 4'd3},  // R3 D=1/8
    '{4'd5,  4'd11, 3'd4, 8'd0,   1'b0, 4'd8},  // R8 496
    '{4'd2,  4'd15, 3'd4, 8'd0,   1'b0, 4'd8},  // R8 D=1/64
    '{4'd12, 4'd2,  3'd0, 8'd64,  1'b1, 4'd5},  // R5 ratio 768
    '{4'd9,  4'd3,  3'd0, 8'd16,  1'b0, 4'd6},  // R6 ratio 128
    '{4'd2,  4'd2,  3'd3, 8'd0,   1'b0, 4'd7}   // R7 ratio 279, R9 hold
  };

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // issue one start, wait for done; returns 1 when done seen
  task automatic runCalc(input logic [3:0] f, input logic [3:0] d, output bit seen);
    @(negedge clk);
    fIdx = f; dIdx = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int n = 0; n < 300; n++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 10);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    finishRun();
  end

  initial begin
    bit seen;
    logic [2:0] savedErr;
    int extra;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(divisor == 8'd31 && sample12 && errCode == 3'd0 && !done, "R1",
          "reset divisor", divisor, 31);
    rstN = 1'b1;
    @(negedge clk);
    check(sample12 == 1'b1, "R1", "reset sample12", sample12, 1);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      runCalc(v.f, v.d, seen);
      check(seen, $sformatf("R%0d", v.req), "done seen", seen, 1);
      if (v.err == 3'd0) begin
        modelDiv = v.dv;
        modelS12 = v.s12;
      end
      check(errCode == v.err, $sformatf("R%0d", v.req), "errCode", errCode, v.err);
      // R9: errors keep the last good settings
      check(divisor == modelDiv && sample12 == modelS12, $sformatf("R%0d", v.req),
            "divisor", {sample12, divisor}, {modelS12, modelDiv});
      @(negedge clk);
      // R10 one-cycle pulse
      check(!done, "R10", "done width", done, 0);
    end

    // R2 invalid index latency: done visible at first negedge after start edge
    @(negedge clk);
    fIdx = 4'd8; dIdx = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && errCode == 3'd1, "R2", "invalid latency", {done, errCode}, 4'b1001);

    // R10 errCode holds between calculations
    savedErr = errCode;
    repeat (20) @(negedge clk);
    check(errCode == savedErr, "R10", "errCode hold", errCode, savedErr);

    // R11 start during a run is ignored
    runCalc(4'd13, 4'd5, seen);  // set state to 16 / 8x
    check(divisor == 8'd16 && !sample12, "R11", "setup", divisor, 16);
    @(negedge clk);
    fIdx = 4'd1; dIdx = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    fIdx = 4'd9; dIdx = 4'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int n = 0; n < 300; n++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    check(seen && divisor == 8'd31 && sample12, "R11", "first result kept",
          divisor, 31);
    extra = 0;
    @(negedge clk);
    for (int n = 0; n < 100; n++) begin
      if (done) extra++;
      @(negedge clk);
    end
    check(extra == 0, "R11", "no second done", extra, 0);

    finishRun();
  end
endmodule